// File: doc/BRIEF.md
# Triaxial Sample Capture Buffer

This block sits behind a three-axis sensor datapath and buffers up to 32 acceleration triplets (X, Y and Z words taken together) so that a host can fetch them in bursts. Each triplet comes in on a one-cycle valid strobe. The host pops triplets one at a time from the head port, and it watches a fill count, a watermark flag and an overflow flag.

A two-bit mode input selects the behaviour:

- `00`: the buffer is off.
- `01`: ring. When the buffer is full, the oldest triplet is replaced.
- `10`: halt. When the buffer is full, new triplets are refused.
- `11`: capture. The buffer acts as a ring until an enabled event source rises. After that it fills up and then holds its contents.

In capture mode the watermark flag stops comparing the fill count and instead reports that the event has arrived. A one-bit output tells the status path whether the buffer, and not the live sample register, should be reported.

The system can switch between its active rate and its low-power rate. When it does, the buffer is emptied unless a keep control is set.

Top module: `sfifo_capture`

## Requirements
- R1: After reset the fill count is 0, the watermark and overflow flags are 0 and the head-valid output is 0.
- R2: Accepted triplets leave the head port in arrival order. A pop removes the head and lowers the count by one. A pop on an empty buffer has no effect. A pop and a write in the same cycle leave the count unchanged.
- R3: In mode `10` (halt), a write to a full buffer is dropped, the stored contents are unchanged and the overflow flag is set.
- R4: In mode `01` (ring), a write to a full buffer discards the oldest triplet, stores the new one, keeps the count at 32 and sets the overflow flag.
- R5: A status-read strobe clears the overflow flag. If a discard happens in the same cycle, the flag stays set.
- R6: In modes `01` and `10`, the watermark flag is 1 exactly when the fill count is greater than the watermark level.
- R7: In mode `11`, the watermark flag shows a latched event. The event is set by a 0-to-1 change on a source whose enable bit is 1. Disabled sources have no effect, and neither does a source held high.
- R8: In mode `11`, before the event a full buffer behaves as in ring mode. After the event the buffer fills to 32 and then drops further writes, setting the overflow flag.
- R9: A rate-switch pulse with the keep control at 0 empties the buffer and clears the overflow flag and the latched event. With the keep control at 1 the pulse has no effect.
- R10: In mode `00` the buffer is held empty, writes are ignored and the buffer-status select output is 0. In any other mode that output is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| smp_valid | input | 1 | New triplet strobe |
| smp_x | input | 14 | X word, two's complement |
| smp_y | input | 14 | Y word, two's complement |
| smp_z | input | 14 | Z word, two's complement |
| fifo_mode | input | 2 | 00 off, 01 ring, 10 halt, 11 capture |
| wm_level | input | 6 | Watermark level |
| evt_src | input | 4 | Event source levels |
| evt_en | input | 4 | Event source enables |
| rate_switch | input | 1 | Active/low-power rate change pulse |
| keep_gate | input | 1 | 1 keeps the contents across a rate change |
| rd_pop | input | 1 | Remove the head triplet |
| stat_rd | input | 1 | Status-read strobe, clears overflow |
| fill_cnt | output | 6 | Stored triplet count |
| wm_flag | output | 1 | Watermark or event flag |
| ovf_flag | output | 1 | Overflow flag |
| buf_stat_sel | output | 1 | Status reports buffer state |
| head_valid | output | 1 | Head port holds a triplet |
| head_x | output | 14 | Head X word |
| head_y | output | 14 | Head Y word |
| head_z | output | 14 | Head Z word |

## Verification
The hardest state to reach is capture mode after the event with a completely full buffer. Getting there needs a buffer that first overflowed as a ring, then an event edge on an enabled source, then a partial drain, and then more writes than the free space can take. The stimulus drives exactly these steps in order. A scoreboard queue predicts which triplets survive. The stimulus then drains the buffer, so any wrong choice between replacing and dropping shows up in the order of the triplets that come out. Separate cycles also hold a disabled source high, hold an enabled source high across a flush, and combine a discard with a status read in one cycle.

// File: rtl/sfifo_pkg.sv
package sfifo_pkg;

    localparam int unsigned SMP_W = 14;

    typedef enum logic [1:0] {
        FM_OFF  = 2'b00,
        FM_RING = 2'b01,
        FM_HALT = 2'b10,
        FM_TRIG = 2'b11
    } fmode_e;

    typedef struct packed {
        logic [SMP_W-1:0] x;
        logic [SMP_W-1:0] y;
        logic [SMP_W-1:0] z;
    } triplet_t;

    // full-buffer policy: replace oldest or refuse the newcomer
    function automatic logic replace_on_full(input fmode_e m, input logic evt_seen);
        return (m == FM_RING) || ((m == FM_TRIG) && !evt_seen);
    endfunction

endpackage

// File: rtl/sfifo_store.sv
module sfifo_store
    import sfifo_pkg::*;
#(
    parameter int unsigned DEPTH = 32,
    localparam int unsigned PTR_W = $clog2(DEPTH),
    localparam int unsigned CNT_W = PTR_W + 1
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             flush,
    input  logic             push,
    input  logic             pop,
    input  logic             drop,
    input  triplet_t         din,
    output triplet_t         head,
    output logic [CNT_W-1:0] cnt
);

    triplet_t         mem [DEPTH];
    logic [PTR_W-1:0] wr_p;
    logic [PTR_W-1:0] rd_p;

    function automatic logic [PTR_W-1:0] step_ptr(input logic [PTR_W-1:0] p);
        return (p == PTR_W'(DEPTH - 1)) ? '0 : p + 1'b1;
    endfunction

    always_ff @(posedge clk) begin
        if (push && !flush) begin
            mem[wr_p] <= din;
        end
    end

    always_ff @(posedge clk) begin
        if (rst || flush) begin
            wr_p <= '0;
            rd_p <= '0;
            cnt  <= '0;
        end else begin
            if (push) begin
                wr_p <= step_ptr(wr_p);
            end
            if (pop || drop) begin
                rd_p <= step_ptr(rd_p);
            end
            cnt <= cnt + CNT_W'(push) - CNT_W'(pop) - CNT_W'(drop);
        end
    end

    assign head = mem[rd_p];

    a_r2_cnt_bound: assert property (@(posedge clk) disable iff (rst)
        cnt <= CNT_W'(DEPTH));

    a_r2_single_step: assert property (@(posedge clk) disable iff (rst)
        !flush |=> (cnt == $past(cnt) || cnt == $past(cnt) + 1'b1 || cnt == $past(cnt) - 1'b1));

    a_r9_flush_empties: assert property (@(posedge clk) disable iff (rst)
        flush |=> (cnt == '0));

endmodule

// File: rtl/sfifo_trig.sv
module sfifo_trig #(
    parameter int unsigned NUM_SRC = 4
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               arm,
    input  logic               clear,
    input  logic [NUM_SRC-1:0] src,
    input  logic [NUM_SRC-1:0] en,
    output logic               seen
);

    logic [NUM_SRC-1:0] src_q;
    logic [NUM_SRC-1:0] rise;

    genvar gi;
    generate
        for (gi = 0; gi < NUM_SRC; gi++) begin : g_edge
            assign rise[gi] = en[gi] && src[gi] && !src_q[gi];
        end
    endgenerate

    always_ff @(posedge clk) begin
        if (rst) begin
            src_q <= '0;
            seen  <= 1'b0;
        end else begin
            src_q <= src;
            if (clear) begin
                seen <= 1'b0;
            end else if (arm && (|rise)) begin
                seen <= 1'b1;
            end
        end
    end

    a_r7_seen_needs_arm: assert property (@(posedge clk) disable iff (rst)
        $rose(seen) |-> $past(arm));

    a_r9_clear_drops_evt: assert property (@(posedge clk) disable iff (rst)
        clear |=> !seen);

endmodule

// File: rtl/sfifo_stat.sv
module sfifo_stat
    import sfifo_pkg::*;
#(
    parameter int unsigned CNT_W = 6
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             clear,
    input  logic             rd_clr,
    input  logic             discard,
    input  fmode_e           mode,
    input  logic [CNT_W-1:0] wm_lvl,
    input  logic [CNT_W-1:0] cnt,
    input  logic             evt_seen,
    output logic             ovf,
    output logic             wm
);

    always_ff @(posedge clk) begin
        if (rst || clear) begin
            ovf <= 1'b0;
        end else if (discard) begin
            ovf <= 1'b1;
        end else if (rd_clr) begin
            ovf <= 1'b0;
        end
    end

    always_comb begin
        unique case (mode)
            FM_OFF:  wm = 1'b0;
            FM_TRIG: wm = evt_seen;
            default: wm = (cnt > wm_lvl);
        endcase
    end

    a_r5_read_clears: assert property (@(posedge clk) disable iff (rst)
        (rd_clr && !discard && !clear) |=> !ovf);

    a_r5_discard_sets: assert property (@(posedge clk) disable iff (rst)
        (discard && !clear) |=> ovf);

endmodule

// File: rtl/sfifo_capture.sv
module sfifo_capture
    import sfifo_pkg::*;
#(
    parameter int unsigned DEPTH   = 32,
    parameter int unsigned NUM_SRC = 4,
    localparam int unsigned CNT_W  = $clog2(DEPTH) + 1
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               smp_valid,
    input  logic [SMP_W-1:0]   smp_x,
    input  logic [SMP_W-1:0]   smp_y,
    input  logic [SMP_W-1:0]   smp_z,
    input  logic [1:0]         fifo_mode,
    input  logic [CNT_W-1:0]   wm_level,
    input  logic [NUM_SRC-1:0] evt_src,
    input  logic [NUM_SRC-1:0] evt_en,
    input  logic               rate_switch,
    input  logic               keep_gate,
    input  logic               rd_pop,
    input  logic               stat_rd,
    output logic [CNT_W-1:0]   fill_cnt,
    output logic               wm_flag,
    output logic               ovf_flag,
    output logic               buf_stat_sel,
    output logic               head_valid,
    output logic [SMP_W-1:0]   head_x,
    output logic [SMP_W-1:0]   head_y,
    output logic [SMP_W-1:0]   head_z
);

    fmode_e           mode;
    triplet_t         din;
    triplet_t         head;
    logic [CNT_W-1:0] cnt;
    logic             evt_seen;
    logic             flush_now;
    logic             full;
    logic             pop_ok;
    logic             wr_req;
    logic             push;
    logic             drop;
    logic             discard;

    assign mode      = fmode_e'(fifo_mode);
    assign din       = '{x: smp_x, y: smp_y, z: smp_z};
    assign flush_now = (mode == FM_OFF) || (rate_switch && !keep_gate);
    assign full      = (cnt == CNT_W'(DEPTH));
    assign pop_ok    = rd_pop && (cnt != '0) && !flush_now;
    assign wr_req    = smp_valid && !flush_now;

    always_comb begin
        push    = wr_req;
        drop    = 1'b0;
        discard = 1'b0;
        if (wr_req && full && !pop_ok) begin
            discard = 1'b1;
            if (replace_on_full(mode, evt_seen)) begin
                drop = 1'b1;
            end else begin
                push = 1'b0;
            end
        end
    end

    sfifo_store #(.DEPTH(DEPTH)) store_i (
        .clk   (clk),
        .rst   (rst),
        .flush (flush_now),
        .push  (push),
        .pop   (pop_ok),
        .drop  (drop),
        .din   (din),
        .head  (head),
        .cnt   (cnt)
    );

    sfifo_trig #(.NUM_SRC(NUM_SRC)) trig_i (
        .clk   (clk),
        .rst   (rst),
        .arm   (mode == FM_TRIG),
        .clear (flush_now),
        .src   (evt_src),
        .en    (evt_en),
        .seen  (evt_seen)
    );

    sfifo_stat #(.CNT_W(CNT_W)) stat_i (
        .clk      (clk),
        .rst      (rst),
        .clear    (flush_now),
        .rd_clr   (stat_rd),
        .discard  (discard),
        .mode     (mode),
        .wm_lvl   (wm_level),
        .cnt      (cnt),
        .evt_seen (evt_seen),
        .ovf      (ovf_flag),
        .wm       (wm_flag)
    );

    assign fill_cnt     = cnt;
    assign buf_stat_sel = (mode != FM_OFF);
    assign head_valid   = (cnt != '0);
    assign head_x       = head.x;
    assign head_y       = head.y;
    assign head_z       = head.z;

    a_r3_halt_stays_full: assert property (@(posedge clk) disable iff (rst)
        (mode == FM_HALT && full && !rd_pop && !flush_now) |=> (fill_cnt == CNT_W'(DEPTH)));

    a_r10_off_empty: assert property (@(posedge clk) disable iff (rst)
        (mode == FM_OFF) |=> (fill_cnt == '0));

    a_r8_full_write_flags: assert property (@(posedge clk) disable iff (rst)
        (smp_valid && full && !rd_pop && !flush_now) |=> ovf_flag);

endmodule

// File: tb/sfifo_capture_tb_top.sv
module sfifo_capture_tb_top;
    import sfifo_pkg::*;

    localparam int CLK_PERIOD = 10;
    localparam int DEPTH = 32;

    logic        clk = 1'b0;
    logic        rst;
    logic        smp_valid;
    logic [13:0] smp_x, smp_y, smp_z;
    logic [1:0]  fifo_mode;
    logic [5:0]  wm_level;
    logic [3:0]  evt_src, evt_en;
    logic        rate_switch, keep_gate, rd_pop, stat_rd;
    logic [5:0]  fill_cnt;
    logic        wm_flag, ovf_flag, buf_stat_sel, head_valid;
    logic [13:0] head_x, head_y, head_z;

    int n_chk = 0;
    int n_bad = 0;
    bit done = 0;

    triplet_t exp_q[$];
    bit m_ovf = 0;
    bit m_evt = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    sfifo_capture dut_i (
        .clk(clk), .rst(rst), .smp_valid(smp_valid),
        .smp_x(smp_x), .smp_y(smp_y), .smp_z(smp_z),
        .fifo_mode(fifo_mode), .wm_level(wm_level),
        .evt_src(evt_src), .evt_en(evt_en),
        .rate_switch(rate_switch), .keep_gate(keep_gate),
        .rd_pop(rd_pop), .stat_rd(stat_rd),
        .fill_cnt(fill_cnt), .wm_flag(wm_flag), .ovf_flag(ovf_flag),
        .buf_stat_sel(buf_stat_sel), .head_valid(head_valid),
        .head_x(head_x), .head_y(head_y), .head_z(head_z)
    );

    function automatic triplet_t mk(input int i);
        triplet_t t;
        t.x = 14'(i);
        t.y = 14'(i * 3 + 7);
        t.z = 14'(-i);
        return t;
    endfunction

    task automatic chk(input string req, input string what, input longint act, input longint exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    // compare every observable output against the scoreboard model
    task automatic chk_state(input string req);
        bit exp_wm;
        triplet_t hd;
        hd = '{x: head_x, y: head_y, z: head_z};
        if (fifo_mode == 2'b11) exp_wm = m_evt;
        else if (fifo_mode == 2'b00) exp_wm = 1'b0;
        else exp_wm = (exp_q.size() > int'(wm_level));
        chk(req, "count", fill_cnt, exp_q.size());
        chk(req, "ovf", ovf_flag, m_ovf);
        chk(req, "wm", wm_flag, exp_wm);
        chk(req, "head_valid", head_valid, exp_q.size() != 0);
        if (exp_q.size() != 0) chk(req, "head", hd, exp_q[0]);
    endtask

    // driver: one clock of stimulus, with the expected effect on the model
    task automatic cyc(input bit v, input int idx, input bit p, input bit rd, input bit rsw);
        bit disc;
        smp_valid = v; {smp_x, smp_y, smp_z} = mk(idx);
        rd_pop = p; stat_rd = rd; rate_switch = rsw;
        disc = 0;
        if (fifo_mode == 2'b00 || (rsw && !keep_gate)) begin
            exp_q.delete(); m_ovf = 0; m_evt = 0;
        end else begin
            if (p && exp_q.size() > 0) void'(exp_q.pop_front());
            if (v) begin
                if (exp_q.size() < DEPTH) exp_q.push_back(mk(idx));
                else begin
                    disc = 1;
                    if (fifo_mode == 2'b01 || (fifo_mode == 2'b11 && !m_evt)) begin
                        void'(exp_q.pop_front());
                        exp_q.push_back(mk(idx));
                    end
                end
            end
            if (disc) m_ovf = 1;
            else if (rd) m_ovf = 0;
        end
        @(posedge clk); #1;
        smp_valid = 0; rd_pop = 0; stat_rd = 0; rate_switch = 0;
    endtask

    // monitor side: compare head with scoreboard, then pop
    task automatic pop_chk(input string req);
        triplet_t hd;
        hd = '{x: head_x, y: head_y, z: head_z};
        if (exp_q.size() != 0) chk(req, "popped", hd, exp_q[0]);
        cyc(0, 0, 1, 0, 0);
    endtask

    initial begin
        #(CLK_PERIOD * 150000);
        if (!done) begin
            n_bad++; n_chk++;
            $display("FAIL watchdog expired actual=1 expected=0");
            $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        rst = 1; smp_valid = 0; smp_x = 0; smp_y = 0; smp_z = 0;
        fifo_mode = 2'b00; wm_level = 6'd5; evt_src = 0; evt_en = 0;
        rate_switch = 0; keep_gate = 0; rd_pop = 0; stat_rd = 0;
        repeat (3) @(posedge clk);
        #1 rst = 0;
        // R1 reset state
        chk_state("R1");
        chk("R1", "sel", buf_stat_sel, 0);

        // R10 off mode ignores writes
        for (int i = 0; i < 3; i++) cyc(1, i, 0, 0, 0);
        chk_state("R10");
        chk("R10", "sel_off", buf_stat_sel, 0);

        // ring mode, watermark around level 5
        fifo_mode = 2'b01;
        #1 chk("R10", "sel_on", buf_stat_sel, 1);
        for (int i = 1; i <= 5; i++) cyc(1, i, 0, 0, 0);
        chk_state("R6");
        cyc(1, 6, 0, 0, 0);
        chk_state("R6");
        for (int i = 0; i < 3; i++) pop_chk("R2");
        chk_state("R2");
        cyc(1, 7, 1, 0, 0);
        chk_state("R2");
        // fill past full: oldest replaced
        for (int i = 8; i < 45; i++) cyc(1, i, 0, 0, 0);
        chk_state("R4");
        cyc(0, 0, 0, 1, 0);
        chk_state("R5");
        while (exp_q.size() != 0) pop_chk("R4");
        pop_chk("R2");
        chk_state("R2");

        // rate switch with and without keep
        for (int i = 50; i < 54; i++) cyc(1, i, 0, 0, 0);
        keep_gate = 1;
        cyc(0, 0, 0, 0, 1);
        chk_state("R9");
        keep_gate = 0;
        cyc(0, 0, 0, 0, 1);
        chk_state("R9");

        // halt mode
        fifo_mode = 2'b10;
        for (int i = 100; i < 134; i++) cyc(1, i, 0, 0, 0);
        chk_state("R3");
        cyc(1, 200, 0, 1, 0);
        chk_state("R5");
        cyc(0, 0, 0, 0, 1);
        chk_state("R9");
        for (int i = 100; i < 134; i++) cyc(1, i, 0, 0, 0);
        while (exp_q.size() != 0) pop_chk("R3");
        chk_state("R3");

        // capture mode
        fifo_mode = 2'b11; evt_en = 4'b0010;
        cyc(0, 0, 0, 1, 0);
        evt_src = 4'b0001;
        for (int i = 300; i < 334; i++) cyc(1, i, 0, 0, 0);
        chk_state("R7");
        chk_state("R8");
        evt_src = 4'b0011; m_evt = 1;
        cyc(0, 0, 0, 1, 0);
        chk_state("R7");
        for (int i = 0; i < 5; i++) pop_chk("R8");
        for (int i = 400; i < 407; i++) cyc(1, i, 0, 0, 0);
        chk_state("R8");
        while (exp_q.size() != 0) pop_chk("R8");
        cyc(0, 0, 0, 0, 1);
        chk_state("R9");
        cyc(0, 0, 0, 0, 0);
        chk_state("R7");

        done = 1;
        $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
        $finish;
    end

endmodule